// File: doc/BRIEF.md
# Nibble-Mode Reverse Channel Receiver

This block is the host end of a reverse channel on a parallel port. The peripheral cannot drive the data lines, so it sends one byte as two 4-bit halves over four status inputs. Each half takes one interlocked handshake. The host lowers HostBusy when it can take a half. The peripheral puts the half on the status lines and pulls its strobe (PtrClk) low. The host samples the lines and raises HostBusy to acknowledge. The peripheral then releases the strobe. The block runs this exchange in hardware, rebuilds the byte from the scattered status pins, and offers it on a valid/ready output. It can also raise a one-cycle interrupt when a byte arrives.

Software or a controller holds the request input high while it wants reverse data. The engine starts a byte only when the output register is empty, so the peripheral is held off until the consumer has taken the previous byte. A programmable cycle limit aborts a handshake step if the peripheral stops responding. The same limit applies to each wait of each half. All port inputs pass through a two-stage synchronizer first.

Top module: `nib_rev_rx`

## Requirements
- R1: After reset, host_busy_o is 1 and xfer_active_o, byte_valid_o, irq_o and tmo_err_o are 0.
- R2: With req_i low, or with a byte still held, the block stays idle with host_busy_o high. With req_i high and no byte held, host_busy_o goes low and xfer_active_o goes high.
- R3: The first half carries bits 3..0 and the second half carries bits 7..4. Within a half, the fault line (line_fault_n_i) gives the lowest bit, then line_select_i, then line_paper_i, and line_busy_i gives the highest bit. Pin levels are taken as they are, with no inversion.
- R4: host_busy_o rises on the fourth rising clock edge after line_clk_n_i falls: two synchronizer stages, one edge-detect cycle and one sample cycle. It never rises before the strobe falls. For the second half, host_busy_o falls again only after the strobe has returned high, on the third edge after its rise.
- R5: byte_valid_o rises on the third edge after the strobe returns high at the end of the second half. byte_o then stays unchanged while byte_valid_o is high and byte_ready_i is low. A cycle with both high clears byte_valid_o.
- R6: While byte_valid_o is high, no new handshake starts: host_busy_o stays high and xfer_active_o stays low.
- R7: irq_o is a one-cycle pulse in the first cycle of byte_valid_o, and only when irq_en_i is 1.
- R8: If a handshake wait (strobe fall, or strobe return) lasts tmo_limit_i cycles, the block aborts. tmo_err_o pulses for one cycle, exactly tmo_limit_i cycles after the wait began. host_busy_o is high, xfer_active_o is low, and no byte is delivered.
- R9: A tmo_limit_i of 0 disables the timeout, so a wait may last indefinitely.
- R10: strobe_n_o and init_n_o are held at 1 at all times.
- R11: xfer_active_o stays high throughout both halves of a byte, including between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Level request to receive bytes |
| byte_ready_i | input | 1 | Consumer accepts the held byte |
| irq_en_i | input | 1 | Enables the arrival pulse |
| tmo_limit_i | input | TMO_W | Handshake wait limit in cycles; 0 disables |
| line_clk_n_i | input | 1 | Peripheral strobe, low marks a valid half |
| line_busy_i | input | 1 | Status line, data bit 3 / 7 |
| line_paper_i | input | 1 | Status line, data bit 2 / 6 |
| line_select_i | input | 1 | Status line, data bit 1 / 5 |
| line_fault_n_i | input | 1 | Status line, data bit 0 / 4 |
| host_busy_o | output | 1 | Low: host ready for a half; high: half taken |
| xfer_active_o | output | 1 | High while a reverse transfer is in progress |
| strobe_n_o | output | 1 | Forward strobe, held inactive |
| init_n_o | output | 1 | Peripheral init, held inactive |
| byte_o | output | 8 | Assembled byte |
| byte_valid_o | output | 1 | byte_o holds an unconsumed byte |
| irq_o | output | 1 | One-cycle byte arrival pulse |
| tmo_err_o | output | 1 | One-cycle abort pulse on timeout |

## Verification
A wrong handshake state shows up at host_busy_o within a few cycles of a strobe edge. The acknowledge is then early or late against the fixed four-edge latency, or the second half never gets its ready. A swapped nibble register or a misrouted status bit reaches byte_o as soon as the byte is offered, and a sweep over all 256 values exposes every bit. A faulty wait counter moves the tmo_err_o pulse off its exact cycle, or makes it fire during normal transfers.

// File: rtl/nib_rx_pkg.sv
// Shared types for the nibble-mode reverse receiver.
// Assumes: one byte is always two halves of NIB_W bits.
package nib_rx_pkg;
    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;

    typedef enum logic [1:0] {
        HS_IDLE    = 2'd0,
        HS_WAIT_LO = 2'd1,
        HS_SAMPLE  = 2'd2,
        HS_WAIT_HI = 2'd3
    } hs_state_t;
endpackage

// File: rtl/nib_rx_sync.sv
// Multi-stage synchronizer for asynchronous port lines.
// Assumes: each bit is independent; reset value matches the idle line level.
module nib_rx_sync #(
    parameter int         W       = 5,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw lines into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= RST_VAL;
                    else        stg[0] <= d_i;
                end
            end else begin : g_next
                // Shift through the remaining stages.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[g] <= RST_VAL;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/nib_rx_timer.sv
// Wait-step cycle counter; flags expiry on the last allowed cycle.
// Assumes: clear_i pulses on every state change; limit 0 disables expiry.
module nib_rx_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          waiting_i,
    input  logic          clear_i,
    input  logic [CW-1:0] limit_i,
    output logic          expired_o
);
    logic [CW-1:0] cnt_q;

    // Count cycles spent in one wait step.
    always_ff @(posedge clk) begin
        if (!rst_n || !waiting_i || clear_i) cnt_q <= '0;
        else                                 cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = waiting_i && (limit_i != '0) &&
                       (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/nib_rx_fsm.sv
// Interlocked handshake sequencer for two halves per byte.
// Assumes: pc_i is the synchronized strobe (low = asserted); a strobe
// event in the expiry cycle wins over the timeout.
module nib_rx_fsm
    import nib_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic full_i,
    input  logic pc_i,
    input  logic pc_fall_i,
    input  logic expired_i,
    output logic host_busy_o,
    output logic active_o,
    output logic take_o,
    output logic idx_o,
    output logic done_o,
    output logic abort_o,
    output logic waiting_o,
    output logic clear_o
);
    hs_state_t st_q, st_d;
    logic      idx_q;

    // Next-state selection and event pulses.
    always_comb begin
        st_d    = st_q;
        done_o  = 1'b0;
        abort_o = 1'b0;
        unique case (st_q)
            HS_IDLE:    if (req_i && !full_i) st_d = HS_WAIT_LO;
            HS_WAIT_LO: begin
                if (pc_fall_i)      st_d = HS_SAMPLE;
                else if (expired_i) begin st_d = HS_IDLE; abort_o = 1'b1; end
            end
            HS_SAMPLE:  st_d = HS_WAIT_HI;
            HS_WAIT_HI: begin
                if (pc_i) begin
                    st_d   = idx_q ? HS_IDLE : HS_WAIT_LO;
                    done_o = idx_q;
                end else if (expired_i) begin
                    st_d = HS_IDLE; abort_o = 1'b1;
                end
            end
            default:    st_d = HS_IDLE;
        endcase
    end

    // State and half-index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= HS_IDLE;
            idx_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == HS_IDLE)                            idx_q <= 1'b0;
            else if (st_q == HS_WAIT_HI && st_d == HS_WAIT_LO) idx_q <= 1'b1;
        end
    end

    assign host_busy_o = !(st_q == HS_WAIT_LO || st_q == HS_SAMPLE);
    assign active_o    = (st_q != HS_IDLE);
    assign take_o      = (st_q == HS_SAMPLE);
    assign idx_o       = idx_q;
    assign waiting_o   = (st_q == HS_WAIT_LO || st_q == HS_WAIT_HI);
    assign clear_o     = (st_d != st_q);
endmodule

// File: rtl/nib_rx_asm.sv
// Half collection and output holding register with valid/ready.
// Assumes: done_i only fires while the output register is empty.
module nib_rx_asm
    import nib_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              idx_i,
    input  logic [NIB_W-1:0]  nib_i,
    input  logic              done_i,
    input  logic              ready_i,
    input  logic              irq_en_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              valid_o,
    output logic              irq_o
);
    logic [NIB_W-1:0] lo_q, hi_q;

    // Store each sampled half in its slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (take_i) begin
            if (idx_i) hi_q <= nib_i;
            else       lo_q <= nib_i;
        end
    end

    // Load, hold and release the assembled byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_o  <= '0;
            valid_o <= 1'b0;
            irq_o   <= 1'b0;
        end else begin
            irq_o <= 1'b0;
            if (done_i) begin
                byte_o  <= {hi_q, lo_q};
                valid_o <= 1'b1;
                irq_o   <= irq_en_i;
            end else if (ready_i) begin
                valid_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/nib_rev_rx.sv
// Top: host-side reverse channel receiver over four status lines.
// Assumes: all line inputs are asynchronous to clk; forward-channel
// outputs are held inactive.
module nib_rev_rx
    import nib_rx_pkg::*;
#(
    parameter int TMO_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              byte_ready_i,
    input  logic              irq_en_i,
    input  logic [TMO_W-1:0]  tmo_limit_i,
    input  logic              line_clk_n_i,
    input  logic              line_busy_i,
    input  logic              line_paper_i,
    input  logic              line_select_i,
    input  logic              line_fault_n_i,
    output logic              host_busy_o,
    output logic              xfer_active_o,
    output logic              strobe_n_o,
    output logic              init_n_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_valid_o,
    output logic              irq_o,
    output logic              tmo_err_o
);
    localparam int LINES = NIB_W + 1;

    logic [LINES-1:0] sync_q;
    logic             pc_s, pc_d, pc_fall;
    logic [NIB_W-1:0] nib_s;
    logic             take, idx, done, abort, waiting, clear, expired;

    nib_rx_sync #(.W(LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({line_clk_n_i, line_busy_i, line_paper_i, line_select_i, line_fault_n_i}),
        .q_o   (sync_q)
    );

    assign pc_s  = sync_q[NIB_W];
    assign nib_s = sync_q[NIB_W-1:0];

    // Delay the synchronized strobe for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_d <= 1'b1;
        else        pc_d <= pc_s;
    end
    assign pc_fall = pc_d && !pc_s;

    nib_rx_timer #(.CW(TMO_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .waiting_i (waiting),
        .clear_i   (clear),
        .limit_i   (tmo_limit_i),
        .expired_o (expired)
    );

    nib_rx_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .full_i      (byte_valid_o),
        .pc_i        (pc_s),
        .pc_fall_i   (pc_fall),
        .expired_i   (expired),
        .host_busy_o (host_busy_o),
        .active_o    (xfer_active_o),
        .take_o      (take),
        .idx_o       (idx),
        .done_o      (done),
        .abort_o     (abort),
        .waiting_o   (waiting),
        .clear_o     (clear)
    );

    nib_rx_asm u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_i   (take),
        .idx_i    (idx),
        .nib_i    (nib_s),
        .done_i   (done),
        .ready_i  (byte_ready_i),
        .irq_en_i (irq_en_i),
        .byte_o   (byte_o),
        .valid_o  (byte_valid_o),
        .irq_o    (irq_o)
    );

    // Register the abort event as the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) tmo_err_o <= 1'b0;
        else        tmo_err_o <= abort;
    end

    assign strobe_n_o = 1'b1;
    assign init_n_o   = 1'b1;
endmodule

// File: rtl/nib_rev_rx_chk.sv
// Protocol checker bound to the receiver top.
// Assumes: observes ports plus the edge-detect strobe from the top.
module nib_rev_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       byte_ready_i,
    input logic       host_busy_o,
    input logic       xfer_active_o,
    input logic [7:0] byte_o,
    input logic       byte_valid_o,
    input logic       irq_o,
    input logic       tmo_err_o,
    input logic       pc_fall
);
    AST_HOLD_OFF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o && !xfer_active_o |=> !xfer_active_o); // R6
    AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid_o && !byte_ready_i |=> byte_valid_o && $stable(byte_o)); // R5
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R7
    AST_IRQ_ON_ARRIVAL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> byte_valid_o && !$past(byte_valid_o)); // R7
    AST_TMO_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err_o |-> !xfer_active_o && host_busy_o && !irq_o); // R8
    AST_ACK_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_busy_o) && xfer_active_o |-> $past(pc_fall, 2)); // R4
endmodule

bind nib_rev_rx nib_rev_rx_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .byte_ready_i  (byte_ready_i),
    .host_busy_o   (host_busy_o),
    .xfer_active_o (xfer_active_o),
    .byte_o        (byte_o),
    .byte_valid_o  (byte_valid_o),
    .irq_o         (irq_o),
    .tmo_err_o     (tmo_err_o),
    .pc_fall       (pc_fall)
);

// File: tb/nib_rev_rx_test.sv
module nib_rev_rx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0, byte_ready_i = 1'b0, irq_en_i = 1'b0;
    logic [15:0] tmo_limit_i = 16'd20;
    logic        line_clk_n_i = 1'b1, line_busy_i = 1'b1, line_paper_i = 1'b1;
    logic        line_select_i = 1'b1, line_fault_n_i = 1'b1;
    logic        host_busy_o, xfer_active_o, strobe_n_o, init_n_o;
    logic [7:0]  byte_o;
    logic        byte_valid_o, irq_o, tmo_err_o;

    int checks = 0;
    int errors = 0;
    bit tmo_allowed = 1'b0;

    always #10 clk = ~clk;

    nib_rev_rx uut (.*);

    task automatic chk(input bit ok, input string r, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Any abort outside the timeout tests is an error.
    always @(negedge clk)
        if (rst_n && tmo_err_o && !tmo_allowed) chk(1'b0, "R8 unexpected abort", 1, 0);

    // Peripheral side of one half-byte handshake.
    task automatic send_half(input logic [3:0] n, input int dly);
        int g = 0;
        while (host_busy_o !== 1'b0 && g < 200) begin @(negedge clk); g++; end
        chk(xfer_active_o === 1'b1, "R11 active during half", int'(xfer_active_o), 1);
        {line_busy_i, line_paper_i, line_select_i, line_fault_n_i} = n;
        @(negedge clk);
        for (int k = 0; k < dly; k++) begin
            chk(host_busy_o === 1'b0, "R4 no ack before strobe", int'(host_busy_o), 0);
            @(negedge clk);
        end
        line_clk_n_i = 1'b0;
        g = 0;
        while (host_busy_o !== 1'b1 && g < 200) begin @(negedge clk); g++; end
        chk(g == 4, "R4 ack latency", g, 4);
        repeat (dly) @(negedge clk);
        line_clk_n_i = 1'b1;
        @(negedge clk);
        chk(host_busy_o === 1'b1, "R4 no ready before strobe return", int'(host_busy_o), 1);
    endtask

    task automatic wait_valid(output int g);
        g = 0;
        while (byte_valid_o !== 1'b1 && g < 20) begin @(negedge clk); g++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int g;
        logic irq_at;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        // R1 / R10: reset state
        chk(host_busy_o === 1'b1, "R1 host_busy", int'(host_busy_o), 1);
        chk(xfer_active_o === 1'b0, "R1 active", int'(xfer_active_o), 0);
        chk(byte_valid_o === 1'b0, "R1 valid", int'(byte_valid_o), 0);
        chk(irq_o === 1'b0 && tmo_err_o === 1'b0, "R1 irq/tmo", int'(irq_o | tmo_err_o), 0);
        chk(strobe_n_o === 1'b1 && init_n_o === 1'b1, "R10 idle lines", int'(strobe_n_o & init_n_o), 1);
        rst_n = 1'b1;
        // R2: idle without request
        repeat (5) @(negedge clk);
        chk(host_busy_o === 1'b1 && xfer_active_o === 1'b0, "R2 idle without req",
            int'(host_busy_o), 1);
        req_i = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(host_busy_o === 1'b0 && xfer_active_o === 1'b1, "R2 start on req",
            int'(host_busy_o), 0);

        // Exhaustive byte sweep with varied peripheral pacing.
        for (int b = 0; b < 256; b++) begin
            irq_en_i = b[0];
            send_half(b[3:0], b % 3);
            send_half(b[7:4], (b / 3) % 3);
            wait_valid(g);
            chk(g == 2, "R5 valid latency", g, 2);
            chk(byte_o === b[7:0], "R3 byte value", int'(byte_o), b);
            irq_at = irq_o;
            chk(irq_at === irq_en_i, "R7 irq at arrival", int'(irq_at), int'(irq_en_i));
            held = byte_o;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(host_busy_o === 1'b1 && xfer_active_o === 1'b0, "R6 held off while full",
                    int'(xfer_active_o), 0);
                chk(byte_valid_o === 1'b1 && byte_o === held, "R5 byte held",
                    int'(byte_o), int'(held));
                chk(irq_o === 1'b0, "R7 irq one cycle", int'(irq_o), 0);
            end
            if (b == 255) req_i = 1'b0;
            byte_ready_i = 1'b1;
            @(negedge clk);
            byte_ready_i = 1'b0;
            @(negedge clk);
            chk(byte_valid_o === 1'b0, "R5 cleared on accept", int'(byte_valid_o), 0);
        end

        // R8: timeout while waiting for the strobe to fall.
        tmo_allowed = 1'b1;
        tmo_limit_i = 16'd7;
        req_i = 1'b1;
        g = 0;
        while (host_busy_o !== 1'b0 && g < 20) begin @(negedge clk); g++; end
        g = 0;
        while (tmo_err_o !== 1'b1 && g < 100) begin @(negedge clk); g++; end
        chk(g == 7, "R8 fall-wait abort cycle", g, 7);
        chk(xfer_active_o === 1'b0 && host_busy_o === 1'b1, "R8 abort state",
            int'(xfer_active_o), 0);
        req_i = 1'b0;
        @(negedge clk);
        chk(tmo_err_o === 1'b0, "R8 pulse width", int'(tmo_err_o), 0);
        chk(byte_valid_o === 1'b0, "R8 no byte", int'(byte_valid_o), 0);

        // R8: timeout while waiting for the strobe to return.
        tmo_limit_i = 16'd9;
        req_i = 1'b1;
        g = 0;
        while (host_busy_o !== 1'b0 && g < 20) begin @(negedge clk); g++; end
        line_clk_n_i = 1'b0;
        g = 0;
        while (host_busy_o !== 1'b1 && g < 20) begin @(negedge clk); g++; end
        g = 0;
        while (tmo_err_o !== 1'b1 && g < 100) begin @(negedge clk); g++; end
        chk(g == 9, "R8 return-wait abort cycle", g, 9);
        chk(xfer_active_o === 1'b0, "R8 abort idle", int'(xfer_active_o), 0);
        req_i = 1'b0;
        @(negedge clk);
        line_clk_n_i = 1'b1;
        repeat (4) @(negedge clk);
        chk(byte_valid_o === 1'b0, "R8 no byte after abort", int'(byte_valid_o), 0);
        tmo_allowed = 1'b0;

        // R9: limit 0 waits indefinitely, then completes normally.
        tmo_limit_i = 16'd0;
        req_i = 1'b1;
        irq_en_i = 1'b1;
        g = 0;
        repeat (300) begin
            @(negedge clk);
            if (tmo_err_o === 1'b1 || host_busy_o !== 1'b0) g++;
        end
        chk(g <= 2, "R9 no timeout when disabled", g, 0);
        send_half(4'h5, 1);
        send_half(4'hA, 0);
        wait_valid(g);
        chk(byte_o === 8'hA5, "R9 byte after long wait", int'(byte_o), 165);
        req_i = 1'b0;
        byte_ready_i = 1'b1;
        @(negedge clk);
        byte_ready_i = 1'b0;
        @(negedge clk);
        chk(strobe_n_o === 1'b1 && init_n_o === 1'b1, "R10 lines at end",
            int'(strobe_n_o & init_n_o), 1);
        finish_run();
    end
endmodule